// File: doc/BRIEF.md
# Multi-channel frame-relative pulse generator

This block drives a bank of independent output lanes. Each lane produces one pulse per frame whose rising and falling points are given as counts relative to the start of the frame. A timing controller outside the block supplies the shared frame count, a running flag, an armed flag and a one-cycle frame-end strobe. The block compares the count with each lane's set point and clear point and updates a small set/reset state flop per lane.

Software can rewrite the lane-enable vector at any time. The block stages that vector and applies it only while the controller is armed or on a frame-end strobe, so a lane never switches on or off in the middle of a frame. A per-lane polarity input, combined with a polarity parameter that gives the default level, sets the level each lane shows when it is inactive. The frame counter, the register interface and any clock-domain crossing stay outside this block.

Top module: `pulse_lane_bank`

## Requirements
- R1: While `run_active` is 1, a lane whose applied enable is 1 and whose clear point differs from `frame_cnt` becomes active on the clock edge where `frame_cnt` equals its set point. Its output changes one cycle after the cycle in which the count matched.
- R2: While running, a lane becomes inactive on the edge where `frame_cnt` equals its clear point. At counts that match neither point it keeps its state.
- R3: When a lane's set point equals its clear point, the clear wins and the lane stays inactive.
- R4: While `run_active` is 0, every lane state is 0 after the next clock edge, whatever the count.
- R5: The applied enable vector takes the value of `lane_en_req` on an edge where `armed` or `frame_end` is 1. It keeps its value on every other edge, so changes to the request at other times have no effect.
- R6: A lane whose applied enable bit is 0 has its state held at 0, so its output shows only its polarity level.
- R7: Bit i of every vector belongs to lane i (bit 0 is lane 0). `lane_out[i]` = state[i] XOR `lane_pol[i]` XOR `DEF_POL[i]`, so an inactive lane outputs `lane_pol[i]` XOR `DEF_POL[i]`.
- R8: While `rst_n` is 0, every lane state and the applied enable vector are 0, so `lane_out` equals `lane_pol` XOR `DEF_POL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_active | input | 1 | Controller is in its running state; comparisons are enabled |
| armed | input | 1 | Controller is armed; staged enable vector is applied |
| frame_end | input | 1 | One-cycle strobe at the last count of a frame; staged enable vector is applied |
| frame_cnt | input | CNT_W | Shared frame-relative count |
| set_pts | input | NUM_LANES*CNT_W | Set point of lane i in bits [i*CNT_W +: CNT_W] |
| clr_pts | input | NUM_LANES*CNT_W | Clear point of lane i in bits [i*CNT_W +: CNT_W] |
| lane_en_req | input | NUM_LANES | Requested lane-enable vector, staged until applied |
| lane_pol | input | NUM_LANES | Per-lane polarity inversion |
| lane_out | output | NUM_LANES | Lane output bus |

## Verification
A sweep over every set/clear pair of a 4-lane, 4-bit configuration drives the count through two full frames per pair. Each lane gets a different arrangement of the pair: set before clear, clear before set, equal points, and an offset set point. These cases separate a wrap-around pulse from a normal one and show which action wins when both points match. Separate phases change the enable request with no strobe, then apply it with `armed` or with `frame_end`, so a design that applies the request at once can be told apart from one that stages it. Another phase drops the running flag in the middle of a pulse, and a polarity sweep over all sixteen polarity vectors, with lanes both active and idle, checks the bit-to-lane mapping.

// File: rtl/pulse_bank_pkg.sv
package pulse_bank_pkg;

  localparam int unsigned MAX_LANES = 32;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_FORCE = 2'd3
  } lane_act_e;

  // Priority: not running or disabled forces 0, then clear, then set.
  function automatic lane_act_e pick_action(input logic run,
                                            input logic en,
                                            input logic hit_set,
                                            input logic hit_clr);
    lane_act_e act;
    if (!run || !en)   act = ACT_FORCE;
    else if (hit_clr)  act = ACT_CLEAR;
    else if (hit_set)  act = ACT_SET;
    else               act = ACT_HOLD;
    return act;
  endfunction

endpackage

// File: rtl/lane_enable_stage.sv
module lane_enable_stage #(
  parameter int unsigned NUM_LANES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [NUM_LANES-1:0] en_req,
  output logic [NUM_LANES-1:0] en_act_q
);

  logic [NUM_LANES-1:0] en_act_d;

  always_comb begin
    en_act_d = en_act_q;
    if (load_en) en_act_d = en_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_act_q <= '0;
    else        en_act_q <= en_act_d;
  end

endmodule

// File: rtl/pulse_lane.sv
module pulse_lane
  import pulse_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] set_pt,
  input  logic [CNT_W-1:0] clr_pt,
  output logic             state_q
);

  logic      hit_set;
  logic      hit_clr;
  lane_act_e act;
  logic      state_d;

  assign hit_set = (cnt == set_pt);
  assign hit_clr = (cnt == clr_pt);

  always_comb begin
    act = pick_action(run, en, hit_set, hit_clr);
    unique case (act)
      ACT_SET:   state_d = 1'b1;
      ACT_CLEAR: state_d = 1'b0;
      ACT_FORCE: state_d = 1'b0;
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pulse_lane_bank.sv
module pulse_lane_bank
  import pulse_bank_pkg::*;
#(
  parameter int unsigned          NUM_LANES = 32,
  parameter int unsigned          CNT_W     = 32,
  parameter logic [NUM_LANES-1:0] DEF_POL   = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_active,
  input  logic                       armed,
  input  logic                       frame_end,
  input  logic [CNT_W-1:0]           frame_cnt,
  input  logic [NUM_LANES*CNT_W-1:0] set_pts,
  input  logic [NUM_LANES*CNT_W-1:0] clr_pts,
  input  logic [NUM_LANES-1:0]       lane_en_req,
  input  logic [NUM_LANES-1:0]       lane_pol,
  output logic [NUM_LANES-1:0]       lane_out
);

  localparam int unsigned PT_BITS = NUM_LANES * CNT_W;

  logic                 stage_load;
  logic [NUM_LANES-1:0] en_act;
  logic [NUM_LANES-1:0] lane_state;
  logic [NUM_LANES-1:0] pol_eff;

  assign stage_load = armed | frame_end;

  lane_enable_stage #(
    .NUM_LANES (NUM_LANES)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (stage_load),
    .en_req   (lane_en_req),
    .en_act_q (en_act)
  );

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    localparam int unsigned LO = gi * CNT_W;
    pulse_lane #(
      .CNT_W (CNT_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_active),
      .en      (en_act[gi]),
      .cnt     (frame_cnt),
      .set_pt  (set_pts[LO +: CNT_W]),
      .clr_pt  (clr_pts[LO +: CNT_W]),
      .state_q (lane_state[gi])
    );
  end

  if (PT_BITS == 0 || NUM_LANES > MAX_LANES) begin : g_bad_cfg
    $error("pulse_lane_bank: NUM_LANES must be 1..32");
  end

  assign pol_eff  = lane_pol ^ DEF_POL;
  assign lane_out = lane_state ^ pol_eff;

endmodule

// File: rtl/pulse_lane_bank_chk.sv
module pulse_lane_bank_chk #(
  parameter int unsigned NUM_LANES = 32,
  parameter int unsigned CNT_W     = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run_active,
  input logic                       armed,
  input logic                       frame_end,
  input logic [CNT_W-1:0]           frame_cnt,
  input logic [NUM_LANES*CNT_W-1:0] set_pts,
  input logic [NUM_LANES*CNT_W-1:0] clr_pts,
  input logic [NUM_LANES-1:0]       lane_en_req,
  input logic [NUM_LANES-1:0]       en_act,
  input logic [NUM_LANES-1:0]       lane_state
);

  // R4: not running empties every lane on the next edge
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_active |=> (lane_state == '0));

  // R5: the staged vector only moves on a load strobe
  p_hold_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed || frame_end) |=> $stable(en_act));

  p_load_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed || frame_end) |=> (en_act == $past(lane_en_req)));

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_chk
    localparam int unsigned LO = gi * CNT_W;

    // R1: a set match with no clear match activates the lane
    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_active && en_act[gi] && frame_cnt == set_pts[LO +: CNT_W]
       && frame_cnt != clr_pts[LO +: CNT_W]) |=> lane_state[gi]);

    // R2 and R3: a clear match always deactivates the lane
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_active && frame_cnt == clr_pts[LO +: CNT_W]) |=> !lane_state[gi]);

    // R2: no match keeps the state
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_active && en_act[gi] && frame_cnt != set_pts[LO +: CNT_W]
       && frame_cnt != clr_pts[LO +: CNT_W]) |=> $stable(lane_state[gi]));

    // R6: a disabled lane is held inactive
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_act[gi] |=> !lane_state[gi]);
  end

endmodule

bind pulse_lane_bank pulse_lane_bank_chk #(
  .NUM_LANES (NUM_LANES),
  .CNT_W     (CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_active  (run_active),
  .armed       (armed),
  .frame_end   (frame_end),
  .frame_cnt   (frame_cnt),
  .set_pts     (set_pts),
  .clr_pts     (clr_pts),
  .lane_en_req (lane_en_req),
  .en_act      (en_act),
  .lane_state  (lane_state)
);

// File: tb/pulse_lane_bank_tb_top.sv
`timescale 1ns/1ps
module pulse_lane_bank_tb_top;

  localparam int unsigned N  = 4;
  localparam int unsigned W  = 4;
  localparam logic [N-1:0] DP = 4'b0110;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           run_active;
  logic           armed;
  logic           frame_end;
  logic [W-1:0]   frame_cnt;
  logic [N*W-1:0] set_pts;
  logic [N*W-1:0] clr_pts;
  logic [N-1:0]   lane_en_req;
  logic [N-1:0]   lane_pol;
  logic [N-1:0]   lane_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_en;
  logic [N-1:0] m_st;

  always #10 clk = ~clk;

  pulse_lane_bank #(
    .NUM_LANES (N),
    .CNT_W     (W),
    .DEF_POL   (DP)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_active  (run_active),
    .armed       (armed),
    .frame_end   (frame_end),
    .frame_cnt   (frame_cnt),
    .set_pts     (set_pts),
    .clr_pts     (clr_pts),
    .lane_en_req (lane_en_req),
    .lane_pol    (lane_pol),
    .lane_out    (lane_out)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expect_out();
    return m_st ^ lane_pol ^ DP;
  endfunction

  // one clock: model follows the requirements, compare after the edge
  task automatic step(input string tag);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (!run_active || !m_en[i])                   m_st[i] = 1'b0;
      else if (frame_cnt == clr_pts[i*W +: W])       m_st[i] = 1'b0;
      else if (frame_cnt == set_pts[i*W +: W])       m_st[i] = 1'b1;
    end
    if (armed || frame_end) m_en = lane_en_req;
    @(negedge clk);
    chk(tag, lane_out, expect_out());
  endtask

  task automatic frame(input string tag, input bit strobe_last);
    for (int c = 0; c < 16; c++) begin
      frame_cnt = W'(c);
      frame_end = strobe_last && (c == 15);
      step(tag);
    end
    frame_end = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run_active = 1'b0; armed = 1'b0; frame_end = 1'b0;
    frame_cnt = '0; set_pts = '0; clr_pts = '0; lane_en_req = '0; lane_pol = '0;
    m_en = '0; m_st = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset level", lane_out, DP);
    lane_pol = 4'b1001;
    #1 chk("R8 reset level with polarity", lane_out, 4'b1001 ^ DP);
    lane_pol = '0;
    rst_n = 1'b1;

    // R5/R6: request without a load strobe leaves lanes idle
    set_pts = {4'd2, 4'd2, 4'd2, 4'd2};
    clr_pts = {4'd5, 4'd5, 4'd5, 4'd5};
    lane_en_req = 4'hF;
    run_active  = 1'b1;
    frame("R5 unapplied request", 1'b0);
    chk("R6 disabled lanes idle", lane_out, DP);

    // R5: armed applies the request
    run_active = 1'b0; armed = 1'b1;
    step("R5 armed load");
    armed = 1'b0; run_active = 1'b1;
    frame_cnt = 4'd1; step("R1 before set");
    frame_cnt = 4'd2; step("R1 set match");
    chk("R1 all lanes active", lane_out, 4'hF ^ DP);
    frame_cnt = 4'd3; step("R2 hold");
    frame_cnt = 4'd5; step("R2 clear match");
    chk("R2 all lanes inactive", lane_out, DP);

    // R5: mid-frame change ignored, frame_end applies it
    lane_en_req = 4'b0101;
    frame("R5 ignored mid frame", 1'b1);
    frame("R6 lanes 1 and 3 off", 1'b0);

    // R4: dropping run clears active lanes
    frame_cnt = 4'd2; step("R4 set before drop");
    run_active = 1'b0; frame_cnt = 4'd3; step("R4 not running");
    chk("R4 outputs idle", lane_out, DP);
    frame_cnt = 4'd2; step("R4 no set while stopped");

    // R7: polarity sweep with lanes 0 and 2 active
    run_active = 1'b1; frame_cnt = 4'd2; step("R7 activate");
    frame_cnt = 4'd3;
    for (int p = 0; p < 16; p++) begin
      lane_pol = N'(p);
      step("R7 polarity");
    end
    lane_pol = '0;

    // R1 R2 R3: every set/clear pair, two frames each
    lane_en_req = 4'hF; armed = 1'b1; step("R5 reload"); armed = 1'b0;
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        set_pts = {W'((s + 3) % 16), W'(s), W'(c), W'(s)};
        clr_pts = {W'(c),            W'(s), W'(s), W'(c)};
        frame("R1 R2 R3 sweep", 1'b0);
        frame("R1 R2 R3 sweep", 1'b0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule